// File: doc/BRIEF.md
# Packed Two-Entry Colour Lookup Table

This block is the colour lookup table used when a display pipeline runs in an indexed pixel mode. It holds 256 colour entries, two to each 32-bit storage word, and software reaches the words through a 128-word window on a simple register bus. A second, independent port is used by the pixel path. It takes an 8-bit index and returns 8-bit red, green and blue values, each widened from the 5-bit field in the stored entry.

Each 16-bit entry holds three 5-bit colour fields and one intensity flag. The flag is stored and read back over the bus, but the pixel path ignores it. Byte strobes on bus writes allow one entry of a word to be changed while its partner keeps its value. Both ports give their result one cycle after the request. A bus write can be seen on the pixel port from the next cycle onwards.

Top module: `clut_pair_ram`

## Requirements
- R1: After a synchronous reset, every storage word is zero, and `bus_rdata`, `pix_r`, `pix_g` and `pix_b` are all zero.
- R2: The window is byte offsets 0x200 to 0x3FF on `bus_addr`, and offset bits [8:2] select one of the 128 words. A write outside the window changes no word, including the word its low address bits would alias to. A read outside the window returns zero.
- R3: A read inside the window returns, in the cycle after `bus_rd_en`, the raw 32-bit word as it stood before that clock edge. If a write hits the same word in the same cycle, the read returns the old value.
- R4: On a write, byte lane k (`bus_wdata[8k+7:8k]`) is stored only when `bus_be[k]` is 1. The lanes whose strobe is 0 keep their value.
- R5: Word n holds entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. Bit 0 of `pix_idx` selects the upper half, and bits [7:1] select the word.
- R6: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10].
- R7: Each 5-bit field is driven out as that field shifted left by 3, so the three low output bits are always zero.
- R8: Bit 15 of an entry (the intensity flag) has no effect on `pix_r`, `pix_g` or `pix_b`.
- R9: The pixel outputs show the entry selected by `pix_idx` in the previous cycle. A write at clock edge t is visible to an index presented for edge t+1.
- R10: In a cycle after one in which `bus_rd_en` was low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write request |
| bus_rd_en | input | 1 | Bus read request |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Registered bus read data |
| pix_idx | input | 8 | Pixel-side palette index |
| pix_r | output | 8 | Expanded red |
| pix_g | output | 8 | Expanded green |
| pix_b | output | 8 | Expanded blue |

## Verification
The bench writes to offset 0x400 and then reads word 0. A decoder that kept only address bits [8:2] would corrupt that word. It writes and reads the same word in one cycle, which exposes a read that forwards the new data instead of returning the old value. It uses half-word strobes and pixel lookups on odd and even indices, which expose lane or half-select swaps. It sets the intensity bit and stores asymmetric colour values, which expose a design that leaks the flag into blue or swaps the red and blue fields. A cycle-level reference model then follows long mixed traffic, so any change in latency shows up as a mismatch on the first affected cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int COMP_W  = 5;
    localparam int CHAN_W  = 8;
    localparam int ENTRY_W = 16;
    localparam int WORD_W  = 2 * ENTRY_W;
    localparam int LANES   = WORD_W / 8;

    typedef struct packed {
        logic              intensity;
        logic [COMP_W-1:0] blu;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] red;
    } clut_entry_t;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    function automatic logic [CHAN_W-1:0] widen(input logic [COMP_W-1:0] c);
        return {c, {(CHAN_W-COMP_W){1'b0}}};
    endfunction

    function automatic rgb_t expand(input clut_entry_t e);
        rgb_t o;
        o.r = widen(e.red);
        o.g = widen(e.grn);
        o.b = widen(e.blu);
        return o;
    endfunction

endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  widx
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WORDS * 4);

    logic [ADDR_W-1:0] offs;
    logic              in_win;
    logic              unused_offs_bits;

    always_comb begin
        offs   = addr - BASE_A;
        in_win = (addr >= BASE_A) && (offs < SPAN_A);
        widx   = offs[IDX_W+1:2];
        wr_hit = wr_en && in_win;
        rd_hit = rd_en && in_win;
    end

    assign unused_offs_bits = ^{offs[1:0], offs[ADDR_W-1:IDX_W+2]};

endmodule

// File: rtl/clut_word_store.sv
module clut_word_store
    import clut_pkg::*;
#(
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [WORD_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [WORD_W-1:0] rb_data
);
    logic [WORDS-1:0][WORD_W-1:0] words_q;
    logic [WORD_W-1:0]            cur_word;
    logic [WORD_W-1:0]            merged;

    assign cur_word = words_q[widx];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*8 +: 8] = be[l] ? wdata[l*8 +: 8] : cur_word[l*8 +: 8];

        AST_LANE_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
            (we && !be[l]) |=> words_q[$past(widx)][l*8 +: 8] == $past(cur_word[l*8 +: 8])); // R4
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else if (we) begin
            words_q[widx] <= merged;
        end
    end

    assign ra_data = words_q[ra_idx];
    assign rb_data = words_q[rb_idx];

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(words_q)); // R2

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && (&be)) |=> words_q[$past(widx)] == $past(wdata)); // R3

endmodule

// File: rtl/clut_expand.sv
module clut_expand
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              sel_hi,
    output rgb_t              rgb_q
);
    clut_entry_t ent;
    logic        unused_intensity;

    assign ent = sel_hi ? clut_entry_t'(word_in[WORD_W-1:ENTRY_W])
                        : clut_entry_t'(word_in[ENTRY_W-1:0]);
    assign unused_intensity = ent.intensity;

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_q <= '0;
        end else begin
            rgb_q <= expand(ent);
        end
    end

endmodule

// File: rtl/clut_pair_ram.sv
module clut_pair_ram
    import clut_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS),
    localparam int PIX_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    input  logic [PIX_W-1:0]  pix_idx,
    output logic [7:0]        pix_r,
    output logic [7:0]        pix_g,
    output logic [7:0]        pix_b
);
    logic              wr_hit;
    logic              rd_hit;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] ra_data;
    logic [WORD_W-1:0] rb_data;
    logic [WORD_W-1:0] rdata_q;
    rgb_t              rgb_q;

    clut_bus_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_dec (
        .addr   (bus_addr),
        .wr_en  (bus_wr_en),
        .rd_en  (bus_rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit),
        .widx   (widx)
    );

    clut_word_store #(.WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_hit),
        .widx    (widx),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .ra_idx  (widx),
        .ra_data (ra_data),
        .rb_idx  (pix_idx[PIX_W-1:1]),
        .rb_data (rb_data)
    );

    clut_expand u_exp (
        .clk     (clk),
        .rst     (rst),
        .word_in (rb_data),
        .sel_hi  (pix_idx[0]),
        .rgb_q   (rgb_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_hit ? ra_data : '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign pix_r     = rgb_q.r;
    assign pix_g     = rgb_q.g;
    assign pix_b     = rgb_q.b;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> bus_rdata == '0); // R10

    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && !rd_hit) |=> bus_rdata == '0); // R2

endmodule

// File: tb/clut_pair_ram_tb_top.sv
`timescale 1ns/1ps
module clut_pair_ram_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [11:0] bus_addr  = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be    = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx   = '0;
    logic [7:0]  pix_r, pix_g, pix_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    clut_pair_ram dut_i (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .pix_idx(pix_idx),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    // behavioural reference: reads take pre-edge contents, then writes apply
    logic [31:0] ref_mem [128];
    logic [31:0] exp_rdata;
    logic [7:0]  exp_r, exp_g, exp_b;

    always @(posedge clk) begin
        if (rst) begin
            foreach (ref_mem[i]) ref_mem[i] = 32'h0;
            exp_rdata = 0; exp_r = 0; exp_g = 0; exp_b = 0;
        end else begin
            bit   in_win;
            int   w;
            int   ent;
            in_win = (bus_addr >= 12'h200) && (bus_addr < 12'h400);
            w      = (int'(bus_addr) - 'h200) / 4;
            exp_rdata = (bus_rd_en && in_win) ? ref_mem[w] : 32'h0;
            ent = pix_idx[0] ? int'(ref_mem[pix_idx / 2][31:16])
                             : int'(ref_mem[pix_idx / 2][15:0]);
            exp_r = 8'((ent % 32) * 8);
            exp_g = 8'(((ent / 32) % 32) * 8);
            exp_b = 8'(((ent / 1024) % 32) * 8);
            if (bus_wr_en && in_win)
                for (int b = 0; b < 4; b++)
                    if (bus_be[b]) ref_mem[w][b*8 +: 8] = bus_wdata[b*8 +: 8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle model comparison (R3 read data, R9 pixel latency)
    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk("R3 model rdata", bus_rdata, exp_rdata);
            chk("R9 model pixel", {8'h0, pix_r, pix_g, pix_b}, {8'h0, exp_r, exp_g, exp_b});
        end
    end

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr_en = 0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 0;
        d = bus_rdata;
    endtask

    task automatic plook(input logic [7:0] i, output logic [23:0] c);
        @(negedge clk);
        pix_idx = i;
        @(negedge clk);
        c = {pix_r, pix_g, pix_b};
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [23:0] c;
        repeat (3) @(negedge clk);
        rst = 0;
        model_on = 1;
        @(negedge clk);
        // R1: reset contents and outputs
        chk("R1 rdata after reset", bus_rdata, 0);
        bread(12'h200, d);  chk("R1 word0 zero", d, 0);
        bread(12'h3FC, d);  chk("R1 word127 zero", d, 0);
        plook(8'd255, c);   chk("R1 pixel 255 zero", {8'h0, c}, 0);
        // R2: outside window
        bwrite(12'h100, 32'hCAFEF00D, 4'hF);
        bread(12'h100, d);  chk("R2 read outside zero", d, 0);
        bwrite(12'h400, 32'h12345678, 4'hF);
        bread(12'h200, d);  chk("R2 alias word untouched", d, 0);
        // R3: raw readback
        bwrite(12'h204, 32'hDEADBEEF, 4'hF);
        bread(12'h204, d);  chk("R3 raw readback", d, 32'hDEADBEEF);
        // R4: byte strobes
        bwrite(12'h204, 32'h12345678, 4'b0011);
        bread(12'h204, d);  chk("R4 low half only", d, 32'hDEAD5678);
        bwrite(12'h204, 32'hAABBCCDD, 4'b0100);
        bread(12'h204, d);  chk("R4 single lane", d, 32'hDEBB5678);
        // R3: same-cycle read and write returns old value
        @(negedge clk);
        bus_wr_en = 1; bus_rd_en = 1; bus_addr = 12'h204; bus_wdata = 32'h0; bus_be = 4'hF;
        @(negedge clk);
        bus_wr_en = 0; bus_rd_en = 0;
        chk("R3 read-during-write old", bus_rdata, 32'hDEBB5678);
        // R10: idle read data
        @(negedge clk);
        chk("R10 idle rdata zero", bus_rdata, 0);
        // R5 R6 R7: word 2 holds entries 4 and 5
        bwrite(12'h208, 32'h401F0C41, 4'hF);
        plook(8'd4, c);  chk("R5 R6 R7 entry4 even half", {8'h0, c}, {8'h0, 8'd8, 8'd16, 8'd24});
        plook(8'd5, c);  chk("R5 R6 R7 entry5 odd half", {8'h0, c}, {8'h0, 8'd248, 8'd0, 8'd128});
        // R8: intensity ignored
        bwrite(12'h20C, 32'h0C418C41, 4'hF);
        plook(8'd6, c);  chk("R8 intensity set", {8'h0, c}, {8'h0, 8'd8, 8'd16, 8'd24});
        plook(8'd7, c);  chk("R8 intensity clear", {8'h0, c}, {8'h0, 8'd8, 8'd16, 8'd24});
        // R9: write at edge t seen by lookup at edge t+1
        @(negedge clk);
        bus_wr_en = 1; bus_addr = 12'h3FC; bus_wdata = 32'h7FFF0000; bus_be = 4'hC;
        @(negedge clk);
        bus_wr_en = 0; pix_idx = 8'd255;
        @(negedge clk);
        chk("R9 write visible next cycle", {8'h0, pix_r, pix_g, pix_b}, {8'h0, 8'd248, 8'd248, 8'd248});
        // mixed traffic checked by the model each cycle
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            bus_wr_en = ($urandom_range(0, 2) == 0);
            bus_rd_en = ($urandom_range(0, 1) == 0);
            bus_addr  = ($urandom_range(0, 7) == 0) ? 12'($urandom_range(0, 4095))
                                                    : 12'(12'h200 + 4 * $urandom_range(0, 127));
            bus_wdata = $urandom;
            bus_be    = 4'($urandom_range(0, 15));
            pix_idx   = 8'($urandom_range(0, 255));
        end
        @(negedge clk);
        bus_wr_en = 0; bus_rd_en = 0;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule